// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 24-bit virtual address into a 32-bit physical address. It reads translation descriptors from memory, one at a time. The virtual space is cut into sixteen 1 MB regions. Each region has one 32-bit entry in a first-level table, whose base address comes in on a port. That entry either maps the whole region directly, marks it as a fault, or points to a second-level table. The second-level table comes in two kinds. The coarse kind has 256 entries and holds 64 KB and 4 KB pages. The fine kind has 1024 entries and also holds 1 KB pages. A larger page is stored by repeating its descriptor in every slot that it covers.

A request is accepted on a valid/ready handshake. The walker owns a memory read port that allows only one read in flight. The result is held on a valid/ready response port until it is taken. The result is either a physical address or a fault. A fault carries the table level (1 or 2) and the virtual address that failed. Addresses below the internal-memory limit (0x028000) skip translation. They come back unchanged, with no table read.

Top module: `xlat_walk_top`

## Requirements
- R1: A virtual address below 0x028000 returns physical address {8'h00, va}, no fault, level 0, and issues no memory read.
- R2: The first-level read address is the table base plus 4 × va[23:20].
- R3: A first-level descriptor with bits [1:0] = 00 returns a fault at level 1 after exactly one read. This includes addresses in region 0 at or above 0x028000.
- R4: A first-level descriptor with bits [1:0] = 10 maps a 1 MB region: physical address {desc[31:20], va[19:0]}, after exactly one read.
- R5: A first-level descriptor with bits [1:0] = 01 selects a coarse table. The second read goes to {desc[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0] = 11 selects a fine table. The second read goes to {desc[31:12], va[19:10], 2'b00}.
- R7: The second-level descriptor type sits in bits [1:0]:
  - 01 is a 64 KB page, giving {desc[31:16], va[15:0]}.
  - 10 is a 4 KB page, giving {desc[31:12], va[11:0]}.
  - 11 is a 1 KB page, giving {desc[31:10], va[9:0]}, but only in a fine table.
  - 00, or 11 found in a coarse table, returns a fault at level 2.
  - Every repeated copy of a page descriptor gives the same result.
- R8: A memory read that returns with the error flag set returns a fault at the level of that read. Every fault reports the virtual address of the request.
- R9: Only one walk runs at a time. `req_ready` is high only when the walker is idle. A memory request stays asserted, with a stable address, until it is accepted. No new read starts while a read is outstanding.
- R10: The response (address, fault flag, level) stays valid and unchanged until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | 32 | First-level table base address, sampled when a request is accepted |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle, request can be accepted |
| req_va | input | 24 | Virtual address to translate |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read failed |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_lvl | output | 2 | Fault level: 1 or 2, and 0 when there is no fault |
| rsp_fault_va | output | 24 | Virtual address of the request |

## Verification
The bench sweeps every first-level slot. Its memory model hands out each descriptor type in turn, and it checks that the two table kinds index with different bits. If the coarse and fine index fields were swapped, or the page offset widths were wrong, the translated addresses would come out wrong. Offsets are spread so that different copies of the same 64 KB descriptor get read. A walker that took the page base from the low index bits would then disagree between copies. Two cases sit right at the internal-memory limit: 0x027FFF and 0x028000. They catch an off-by-one that either translates an internal address or passes through an external one. The bench also counts the reads of every walk. This shows the bypass path as wrongly touching memory, a 1 KB descriptor in a coarse table as wrongly accepted, and an injected read error as reported at the wrong level.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT,
      ST_RESP
   } walk_st_e;

   // First-level descriptor kinds, encoded in descriptor bits [1:0]
   typedef enum logic [1:0] {
      L1_FAULT   = 2'b00,
      L1_COARSE  = 2'b01,
      L1_SECTION = 2'b10,
      L1_FINE    = 2'b11
   } l1_kind_e;

   // Second-level descriptor kinds, encoded in descriptor bits [1:0]
   typedef enum logic [1:0] {
      L2_FAULT = 2'b00,
      L2_LARGE = 2'b01,
      L2_SMALL = 2'b10,
      L2_TINY  = 2'b11
   } l2_kind_e;

   localparam int REGION_SHIFT = 20;
   localparam int LARGE_SHIFT  = 16;
   localparam int SMALL_SHIFT  = 12;
   localparam int TINY_SHIFT   = 10;
endpackage

// File: rtl/xlat_l1_dec.sv
module xlat_l1_dec
   import xlat_pkg::*;
#(
   parameter int VA_W   = 24,
   parameter int DESC_W = 32
)(
   input  logic [DESC_W-1:0] desc,
   input  logic [VA_W-1:0]   va,
   output l1_kind_e          kind,
   output logic [DESC_W-1:0] region_pa,
   output logic [DESC_W-1:0] next_addr
);
   always_comb begin
      kind      = l1_kind_e'(desc[1:0]);
      region_pa = {desc[DESC_W-1:REGION_SHIFT], va[REGION_SHIFT-1:0]};
      unique case (kind)
         L1_COARSE: next_addr = {desc[DESC_W-1:TINY_SHIFT],  va[REGION_SHIFT-1:SMALL_SHIFT], 2'b00};
         L1_FINE:   next_addr = {desc[DESC_W-1:SMALL_SHIFT], va[REGION_SHIFT-1:TINY_SHIFT],  2'b00};
         default:   next_addr = '0;
      endcase
   end
endmodule

// File: rtl/xlat_l2_dec.sv
module xlat_l2_dec
   import xlat_pkg::*;
#(
   parameter int VA_W   = 24,
   parameter int DESC_W = 32
)(
   input  logic [DESC_W-1:0] desc,
   input  logic [VA_W-1:0]   va,
   input  logic              fine_tbl,
   output logic              fault,
   output logic [DESC_W-1:0] page_pa
);
   l2_kind_e kind;

   always_comb begin
      kind    = l2_kind_e'(desc[1:0]);
      fault   = 1'b0;
      page_pa = '0;
      unique case (kind)
         L2_LARGE: page_pa = {desc[DESC_W-1:LARGE_SHIFT], va[LARGE_SHIFT-1:0]};
         L2_SMALL: page_pa = {desc[DESC_W-1:SMALL_SHIFT], va[SMALL_SHIFT-1:0]};
         L2_TINY: begin
            if (fine_tbl) page_pa = {desc[DESC_W-1:TINY_SHIFT], va[TINY_SHIFT-1:0]};
            else          fault   = 1'b1;
         end
         default:  fault = 1'b1;
      endcase
   end
endmodule

// File: rtl/xlat_walk_top.sv
module xlat_walk_top
   import xlat_pkg::*;
#(
   parameter int          VA_W       = 24,
   parameter int          PA_W       = 32,
   parameter int          DESC_W     = 32,
   parameter bit          BYPASS_EN  = 1'b1,
   parameter logic [31:0] BYPASS_END = 32'h0002_8000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PA_W-1:0]   tbl_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DESC_W-1:0] mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_fault,
   output logic [1:0]        rsp_fault_lvl,
   output logic [VA_W-1:0]   rsp_fault_va
);
   localparam int IDX_W = VA_W - REGION_SHIFT;
   localparam int PAD_W = PA_W - VA_W;
   localparam int OFS_W = PA_W - IDX_W - 2;

   if (PA_W != 32 || DESC_W != 32) begin : g_bad_width
      $error("xlat_walk_top: descriptor and physical width must be 32");
   end
   if (IDX_W < 1 || PAD_W < 1) begin : g_bad_va
      $error("xlat_walk_top: VA_W must lie between 21 and PA_W-1");
   end

   walk_st_e          st_q;
   logic [VA_W-1:0]   va_q;
   logic [PA_W-1:0]   addr_q;
   logic              fine_q;
   logic [PA_W-1:0]   pa_q;
   logic              fault_q;
   logic [1:0]        lvl_q;
   logic              in_win;

   // Internal-memory window: chosen at elaboration
   if (BYPASS_EN) begin : g_win
      assign in_win = ({{(32-VA_W){1'b0}}, req_va} < BYPASS_END);
   end else begin : g_no_win
      assign in_win = 1'b0;
   end

   l1_kind_e          l1_kind;
   logic [PA_W-1:0]   l1_region_pa;
   logic [PA_W-1:0]   l1_next;
   logic              l2_fault;
   logic [PA_W-1:0]   l2_pa;

   xlat_l1_dec #(.VA_W(VA_W), .DESC_W(DESC_W)) u_l1 (
      .desc      (mem_rsp_data),
      .va        (va_q),
      .kind      (l1_kind),
      .region_pa (l1_region_pa),
      .next_addr (l1_next)
   );

   xlat_l2_dec #(.VA_W(VA_W), .DESC_W(DESC_W)) u_l2 (
      .desc     (mem_rsp_data),
      .va       (va_q),
      .fine_tbl (fine_q),
      .fault    (l2_fault),
      .page_pa  (l2_pa)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         va_q    <= '0;
         addr_q  <= '0;
         fine_q  <= 1'b0;
         pa_q    <= '0;
         fault_q <= 1'b0;
         lvl_q   <= 2'd0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               va_q <= req_va;
               if (in_win) begin
                  pa_q    <= {{PAD_W{1'b0}}, req_va};
                  fault_q <= 1'b0;
                  lvl_q   <= 2'd0;
                  st_q    <= ST_RESP;
               end else begin
                  addr_q <= tbl_base + {{OFS_W{1'b0}}, req_va[VA_W-1:REGION_SHIFT], 2'b00};
                  st_q   <= ST_L1_REQ;
               end
            end
            ST_L1_REQ: if (mem_req_ready) st_q <= ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) begin
               if (mem_rsp_err || l1_kind == L1_FAULT) begin
                  pa_q    <= '0;
                  fault_q <= 1'b1;
                  lvl_q   <= 2'd1;
                  st_q    <= ST_RESP;
               end else if (l1_kind == L1_SECTION) begin
                  pa_q    <= l1_region_pa;
                  fault_q <= 1'b0;
                  lvl_q   <= 2'd0;
                  st_q    <= ST_RESP;
               end else begin
                  addr_q <= l1_next;
                  fine_q <= (l1_kind == L1_FINE);
                  st_q   <= ST_L2_REQ;
               end
            end
            ST_L2_REQ: if (mem_req_ready) st_q <= ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) begin
               fault_q <= mem_rsp_err || l2_fault;
               lvl_q   <= (mem_rsp_err || l2_fault) ? 2'd2 : 2'd0;
               pa_q    <= (mem_rsp_err || l2_fault) ? '0 : l2_pa;
               st_q    <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
   assign mem_req_addr  = addr_q;
   assign rsp_valid     = (st_q == ST_RESP);
   assign rsp_pa        = pa_q;
   assign rsp_fault     = fault_q;
   assign rsp_fault_lvl = lvl_q;
   assign rsp_fault_va  = va_q;

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
   // R9
   one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
   // R10
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
                                  && $stable(rsp_fault_lvl));
   // R8
   fault_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault ? (rsp_fault_lvl == 2'd1 || rsp_fault_lvl == 2'd2)
                               : (rsp_fault_lvl == 2'd0)));
   // R1
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && in_win |=> rsp_valid && !rsp_fault && !mem_req_valid
                                          && rsp_pa == {{PAD_W{1'b0}}, $past(req_va)});
endmodule

// File: tb/xlat_walk_top_bench.sv
module xlat_walk_top_bench;
   localparam logic [31:0] TBASE = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tbl_base = TBASE;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_va = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_pa;
   logic        rsp_fault;
   logic [1:0]  rsp_fault_lvl;
   logic [23:0] rsp_fault_va;

   int checks = 0;
   int fails = 0;
   int reads = 0;
   logic [31:0] first_addr = '0;
   logic [31:0] second_addr = '0;
   logic [31:0] err_addr = 32'hFFFF_FFFF;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   xlat_walk_top u_xlat_walk_top (
      .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
      .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl), .rsp_fault_va(rsp_fault_va)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Memory contents are generated from the address
   function automatic logic [31:0] mem_word(input logic [31:0] a);
      int unsigned idx, j, t;
      if (a >= TBASE && a < TBASE + 64) begin
         idx = (a - TBASE) / 4;
         case (idx % 4)
            0: return idx << 4;
            1: return (32'h9000_0000 + idx * 1024) | 1;
            2: return ((32'h300 + idx) << 20) | 2;
            default: return (32'hA000_0000 + idx * 4096) | 3;
         endcase
      end else if (a >= 32'h9000_0000 && a < 32'h9000_4000) begin
         idx = (a - 32'h9000_0000) / 1024;
         j = (a / 4) % 256;
         t = (j / 16) % 4;
         case (t)
            0: return 32'h0000_0F00;
            1: return ((32'h4000 + idx * 16 + j / 16) << 16) | 1;
            2: return ((32'h50000 + idx * 256 + j) << 12) | 2;
            default: return ((32'h100000 + idx * 256 + j) << 10) | 3;
         endcase
      end else if (a >= 32'hA000_0000 && a < 32'hA001_0000) begin
         idx = (a - 32'hA000_0000) / 4096;
         j = (a / 4) % 1024;
         t = (j / 64) % 4;
         case (t)
            0: return 32'h0000_0F00;
            1: return ((32'h6000 + idx * 16 + j / 64) << 16) | 1;
            2: return ((32'h70000 + idx * 256 + j / 4) << 12) | 2;
            default: return ((32'h200000 + idx * 1024 + j) << 10) | 3;
         endcase
      end
      return 32'hDEAD_0000;
   endfunction

   // Memory responder: ready pattern, variable latency, one read in flight
   initial begin
      bit pending = 1'b0;
      int lat = 0;
      int rr = 0;
      logic [31:0] pa_addr = '0;
      forever begin
         @(negedge clk);
         cyc++;
         mem_rsp_valid = 1'b0;
         mem_rsp_err   = 1'b0;
         if (pending) begin
            if (lat == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = mem_word(pa_addr);
               mem_rsp_err   = (pa_addr == err_addr);
               pending = 1'b0;
            end else lat--;
         end
         rr++;
         mem_req_ready = (rr % 3) != 1;
         if (mem_req_valid && mem_req_ready) begin
            if (pending || mem_rsp_valid) chk(1'b0, "R9 read while outstanding", mem_req_addr, 0);
            reads++;
            if (reads == 1) first_addr = mem_req_addr;
            if (reads == 2) second_addr = mem_req_addr;
            pending = 1'b1;
            pa_addr = mem_req_addr;
            lat = rr % 3;
         end
      end
   end

   // Reference result computed from the requirement text
   task automatic model(input logic [23:0] va, output logic [31:0] pa, output bit flt,
                        output int lvl, output int nrd, output logic [31:0] a2);
      int unsigned idx, off, j, t;
      idx = va / 32'h10_0000;
      off = va % 32'h10_0000;
      pa = 0; flt = 0; lvl = 0; a2 = 0;
      if (va < 24'h028000) begin nrd = 0; pa = va; return; end
      nrd = 1;
      case (idx % 4)
         0: begin flt = 1; lvl = 1; end
         2: pa = (32'h300 + idx) * 32'h10_0000 + off;
         1: begin
            nrd = 2; j = off / 4096; t = (j / 16) % 4;
            a2 = 32'h9000_0000 + idx * 1024 + j * 4;
            case (t)
               1: pa = (32'h4000 + idx * 16 + j / 16) * 65536 + va % 65536;
               2: pa = (32'h50000 + idx * 256 + j) * 4096 + va % 4096;
               default: begin flt = 1; lvl = 2; end
            endcase
         end
         default: begin
            nrd = 2; j = off / 1024; t = (j / 64) % 4;
            a2 = 32'hA000_0000 + idx * 4096 + j * 4;
            case (t)
               0: begin flt = 1; lvl = 2; end
               1: pa = (32'h6000 + idx * 16 + j / 64) * 65536 + va % 65536;
               2: pa = (32'h70000 + idx * 256 + j / 4) * 4096 + va % 4096;
               default: pa = (32'h200000 + idx * 1024 + j) * 1024 + va % 1024;
            endcase
         end
      endcase
   endtask

   task automatic walk(input logic [23:0] va, input bit force_flt, input int force_lvl, input string tag);
      logic [31:0] epa, ea2;
      bit eflt;
      int elvl, enrd, wait_n;
      logic [31:0] hpa;
      model(va, epa, eflt, elvl, enrd, ea2);
      if (force_flt) begin eflt = 1; elvl = force_lvl; epa = 0; enrd = force_lvl; end
      reads = 0;
      req_va = va;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait_n = 0;
      while (!rsp_valid && wait_n < 100) begin @(negedge clk); wait_n++; end
      hpa = rsp_pa;
      @(negedge clk);
      @(negedge clk);
      chk(rsp_valid && rsp_pa == hpa, "R10 response held", rsp_pa, hpa);
      chk(rsp_fault == eflt && rsp_pa == epa, {tag, " pa/fault"}, {rsp_fault, rsp_pa[30:0]}, {eflt, epa[30:0]});
      chk(rsp_fault_lvl == elvl[1:0], {tag, " R8 level"}, rsp_fault_lvl, elvl);
      if (eflt) chk(rsp_fault_va == va, {tag, " R8 fault va"}, rsp_fault_va, va);
      chk(reads == enrd, {tag, " read count"}, reads, enrd);
      if (enrd >= 1)
         chk(first_addr == TBASE + 4 * (va / 32'h10_0000), "R2 first-level address", first_addr,
             TBASE + 4 * (va / 32'h10_0000));
      if (enrd == 2 && !force_flt)
         chk(second_addr == ea2, "R5/R6 second-level address", second_addr, ea2);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   initial begin
      while (!done && cyc < 150000) @(negedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && rsp_valid == 1'b0, "reset idle", {req_ready, rsp_valid}, 2'b10);
      chk(mem_req_valid == 1'b0, "reset no read", mem_req_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 window edges
      walk(24'h000000, 0, 0, "R1 bypass zero");
      walk(24'h027FFF, 0, 0, "R1 bypass top");
      walk(24'h028000, 0, 0, "R3 first outside window");
      // R3 R4 R5 R6 R7 sweep over all regions and descriptor types
      for (int idx = 0; idx < 16; idx++) begin
         for (int s = 0; s < 64; s++) begin
            logic [23:0] va;
            va = 24'(idx * 32'h10_0000 + (s * 32'h4213) % 32'h10_0000);
            walk(va, 0, 0, "R4 R7 sweep");
         end
      end
      // R7 two copies of one coarse 64 KB descriptor (region 1, group 1)
      walk(24'h110000, 0, 0, "R7 coarse large copy a");
      walk(24'h11F123, 0, 0, "R7 coarse large copy b");
      // R7 fine 64 KB copies (region 3, entries 64..127)
      walk(24'h310000, 0, 0, "R7 fine large copy a");
      walk(24'h31FFFF, 0, 0, "R7 fine large copy b");
      // R7 1 KB descriptor in a coarse table is a fault
      walk(24'h13A555, 0, 0, "R7 coarse tiny fault");
      // R8 read errors at each level
      err_addr = TBASE + 4 * 5;
      walk(24'h512345, 1, 1, "R8 level-1 error");
      err_addr = 32'hA000_7000 + (24'h223456 % 32'h10_0000) / 1024 * 4;
      walk(24'h723456, 1, 2, "R8 level-2 error");
      err_addr = 32'hFFFF_FFFF;
      walk(24'h723456, 0, 0, "R6 fine after error");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule